// File: doc/BRIEF.md
# Partition Power-Gate Register Controller

This block switches power to up to 32 independent power partitions and controls the isolation clamps on their outputs. Software reaches it through a small synchronous register bus. A power change is a single self-clearing toggle command that names one partition. The controller then raises or removes that partition's power enable. It waits a fixed settle time and then waits for the partition's power-good acknowledge before it reports completion. Only one toggle runs at a time.

Clamp release is a separate command. Software writes a one-hot mask and each requested bit clears by itself once the clamp of that partition opens. A release is granted only for a partition that is powered. A release aimed at an unpowered partition is dropped and leaves a sticky error flag. Powering a partition down always closes its clamp one cycle before the enable is removed.

The register bus has no back-pressure. A write is taken in the cycle `reg_we` is high, and read data is a combinational function of `reg_addr` and the current register state. Accepted commands flow out on plain control pins, with no handshake. Register word offsets: 0 toggle command, 1 power status, 2 clamp-release command, 3 clamp status, 4 error flag.

Top module: `pg_partition_ctrl`

## Requirements
- R1: After reset, every power enable is 0 and every clamp is 1. The power status, the toggle register and the error flag read 0.
- R2: The toggle register (offset 0) has a start flag at bit 8 and a partition ID in bits 4:0. A write with bit 8 set while idle starts a toggle. Bit 8 reads 1 until the toggle completes and then clears by itself. A write with bit 8 clear starts nothing.
- R3: A toggle inverts the powered state of the named partition and leaves every other partition unchanged.
- R4: On power-up, the enable rises in the cycle after the write. Completion takes at least SETTLE_CYC cycles and waits for that partition's power-good input to be high.
- R5: On power-down, the clamp is set in the cycle after the write while the enable is still high. The enable falls one cycle later, and completion waits for power-good to go low.
- R6: The power status register (offset 1) holds bit i = 1 exactly when partition i is powered.
- R7: A toggle write made while bit 8 of the toggle register reads 1 is ignored. The ID field keeps the running partition and no other partition changes.
- R8: The clamp-release command (offset 2) is written one-hot. For a powered partition the bit reads 1 for one cycle, then clears, and that partition's clamp output drops to 0.
- R9: The clamp status register (offset 3) holds bit i = 1 exactly when clamp output i is 1.
- R10: A clamp-release request for an unpowered partition leaves the clamp at 1 and sets bit 0 of the error register (offset 4). The bit stays set until a write of 1 to bit 0 of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Register word offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwr_en | output | NUM_PART | Power switch enable per partition |
| clamp | output | NUM_PART | Isolation clamp per partition, 1 = clamped |
| pwr_good | input | NUM_PART | Power-good acknowledge per partition |

## Verification
A sequencer stuck in a wrong state shows first as a start flag that never clears. A status bit that disagrees with its enable shows within one cycle of the completing edge. A clamp that opens on an unpowered partition, or an enable that drops while its clamp is still open, is visible on the output pins at the very next clock edge. Completion that ignores power-good shows as a status bit set while the acknowledge is held low. A toggle window that accepts a second command corrupts the ID field at once and a second enable within a cycle.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int DATA_W    = 32;
  localparam int ID_W      = 5;
  localparam int START_BIT = 8;

  localparam int OFS_TOGGLE  = 0;
  localparam int OFS_PSTAT   = 1;
  localparam int OFS_UNCLAMP = 2;
  localparam int OFS_CSTAT   = 3;
  localparam int OFS_ERR     = 4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CLAMP,
    SQ_SETTLE,
    SQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/pg_toggle_seq.sv
module pg_toggle_seq
  import pg_pkg::*;
#(
  parameter int NUM_PART   = 32,
  parameter int SETTLE_CYC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ID_W-1:0]     start_id,
  input  logic [NUM_PART-1:0] pwr_good,
  output logic                busy,
  output logic [ID_W-1:0]     cur_id,
  output logic [NUM_PART-1:0] pwr_en,
  output logic [NUM_PART-1:0] pwr_stat,
  output logic [NUM_PART-1:0] clamp_set
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  seq_state_e        state;
  logic              dir_on;
  logic [CNT_W-1:0]  cnt;
  logic              id_ok;
  logic              accept;

  generate
    if (NUM_PART >= 32) begin : g_full
      assign id_ok = 1'b1;
    end else begin : g_part
      assign id_ok = (32'(start_id) < NUM_PART);
    end
  endgenerate

  assign busy   = (state != SQ_IDLE);
  assign accept = start && !busy && id_ok;

  // Clamp closes at the accepting edge of a power-down, ahead of the enable.
  always_comb begin
    clamp_set = '0;
    if (accept && pwr_stat[start_id])
      clamp_set = NUM_PART'(1) << start_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      dir_on   <= 1'b0;
      cnt      <= '0;
      cur_id   <= '0;
      pwr_en   <= '0;
      pwr_stat <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (accept) begin
          cur_id <= start_id;
          if (pwr_stat[start_id]) begin
            dir_on             <= 1'b0;
            pwr_stat[start_id] <= 1'b0;
            state              <= SQ_CLAMP;
          end else begin
            dir_on           <= 1'b1;
            pwr_en[start_id] <= 1'b1;
            cnt              <= CNT_W'(SETTLE_CYC - 1);
            state            <= SQ_SETTLE;
          end
        end
        SQ_CLAMP: begin
          pwr_en[cur_id] <= 1'b0;
          cnt            <= CNT_W'(SETTLE_CYC - 1);
          state          <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (cnt == '0) state <= SQ_WAIT;
          else           cnt   <= cnt - 1'b1;
        end
        SQ_WAIT: if (pwr_good[cur_id] == dir_on) begin
          pwr_stat[cur_id] <= dir_on;
          state            <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pg_clamp_ctrl.sv
module pg_clamp_ctrl #(
  parameter int NUM_PART = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_we,
  input  logic [NUM_PART-1:0] cmd_mask,
  input  logic                err_clr,
  input  logic [NUM_PART-1:0] powered,
  input  logic [NUM_PART-1:0] clamp_set,
  output logic [NUM_PART-1:0] clamp,
  output logic [NUM_PART-1:0] pending,
  output logic                err
);
  generate
    for (genvar i = 0; i < NUM_PART; i++) begin : g_part
      always_ff @(posedge clk) begin
        if (rst) begin
          clamp[i]   <= 1'b1;
          pending[i] <= 1'b0;
        end else begin
          pending[i] <= cmd_we && cmd_mask[i] && powered[i];
          if (clamp_set[i])    clamp[i] <= 1'b1;
          else if (pending[i]) clamp[i] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                                   err <= 1'b0;
    else if (cmd_we && |(cmd_mask & ~powered)) err <= 1'b1;
    else if (err_clr)                          err <= 1'b0;
  end
endmodule

// File: rtl/pg_partition_ctrl.sv
module pg_partition_ctrl
  import pg_pkg::*;
#(
  parameter int NUM_PART   = 32,
  parameter int SETTLE_CYC = 8,
  parameter int ADDR_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_PART-1:0] pwr_en,
  output logic [NUM_PART-1:0] clamp,
  input  logic [NUM_PART-1:0] pwr_good
);
  logic                tog_start;
  logic                tog_busy;
  logic [ID_W-1:0]     tog_id;
  logic [NUM_PART-1:0] pwr_stat;
  logic [NUM_PART-1:0] clamp_set;
  logic [NUM_PART-1:0] unclamp_pend;
  logic                unclamp_we;
  logic                err_clr;
  logic                err_flag;
  logic                unused_wdata;

  assign tog_start  = reg_we && (reg_addr == ADDR_W'(OFS_TOGGLE)) && reg_wdata[START_BIT];
  assign unclamp_we = reg_we && (reg_addr == ADDR_W'(OFS_UNCLAMP));
  assign err_clr    = reg_we && (reg_addr == ADDR_W'(OFS_ERR)) && reg_wdata[0];
  assign unused_wdata = ^reg_wdata;

  pg_toggle_seq #(
    .NUM_PART  (NUM_PART),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (tog_start),
    .start_id (reg_wdata[ID_W-1:0]),
    .pwr_good (pwr_good),
    .busy     (tog_busy),
    .cur_id   (tog_id),
    .pwr_en   (pwr_en),
    .pwr_stat (pwr_stat),
    .clamp_set(clamp_set)
  );

  pg_clamp_ctrl #(
    .NUM_PART(NUM_PART)
  ) u_clamp (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (unclamp_we),
    .cmd_mask (reg_wdata[NUM_PART-1:0]),
    .err_clr  (err_clr),
    .powered  (pwr_stat),
    .clamp_set(clamp_set),
    .clamp    (clamp),
    .pending  (unclamp_pend),
    .err      (err_flag)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_TOGGLE)) begin
      reg_rdata[START_BIT]  = tog_busy;
      reg_rdata[ID_W-1:0]   = tog_id;
    end else if (reg_addr == ADDR_W'(OFS_PSTAT)) begin
      reg_rdata = DATA_W'(pwr_stat);
    end else if (reg_addr == ADDR_W'(OFS_UNCLAMP)) begin
      reg_rdata = DATA_W'(unclamp_pend);
    end else if (reg_addr == ADDR_W'(OFS_CSTAT)) begin
      reg_rdata = DATA_W'(clamp);
    end else if (reg_addr == ADDR_W'(OFS_ERR)) begin
      reg_rdata[0] = err_flag;
    end
  end
endmodule

// File: rtl/pg_partition_ctrl_chk.sv
module pg_partition_ctrl_chk #(
  parameter int NUM_PART = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PART-1:0] pwr_en,
  input logic [NUM_PART-1:0] clamp,
  input logic [NUM_PART-1:0] pwr_good,
  input logic [NUM_PART-1:0] pwr_stat,
  input logic                busy
);
  // R5: an enable may only fall where the clamp was already closed
  a_r5_clamp_before_off: assert property (@(posedge clk) disable iff (rst)
    (($past(pwr_en) & ~pwr_en & ~$past(clamp)) == '0));

  // R8: a clamp may only open on a partition that was powered
  a_r8_open_only_powered: assert property (@(posedge clk) disable iff (rst)
    (($past(clamp) & ~clamp & ~$past(pwr_stat)) == '0));

  // R4: a status bit rises only once power-good was seen
  a_r4_up_needs_good: assert property (@(posedge clk) disable iff (rst)
    ((pwr_stat & ~$past(pwr_stat) & ~$past(pwr_good)) == '0));

  // R7: at most one partition is in transition at any time
  a_r7_single_transition: assert property (@(posedge clk) disable iff (rst)
    ($countones(pwr_en ^ pwr_stat) <= 1));

  // R2: any partition in transition implies the start flag is set
  a_r2_busy_in_transit: assert property (@(posedge clk) disable iff (rst)
    ((pwr_en != pwr_stat) |-> busy));
endmodule

bind pg_partition_ctrl pg_partition_ctrl_chk #(.NUM_PART(NUM_PART)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwr_en  (pwr_en),
  .clamp   (clamp),
  .pwr_good(pwr_good),
  .pwr_stat(pwr_stat),
  .busy    (tog_busy)
);

// File: tb/pg_partition_ctrl_test.sv
`timescale 1ns/1ps
module pg_partition_ctrl_test;
  localparam int N      = 32;
  localparam int SETTLE = 8;
  localparam int AW     = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pwr_en, clamp, pwr_good;
  logic [N-1:0]  d1, d2, d3;
  logic          hold_low = 1'b0;
  int            checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pg_partition_ctrl #(.NUM_PART(N), .SETTLE_CYC(SETTLE), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .pwr_en(pwr_en), .clamp(clamp), .pwr_good(pwr_good));

  // Power switch model: good follows enable after three cycles
  always_ff @(posedge clk) begin
    d1 <= pwr_en; d2 <= d1; d3 <= d2;
  end
  assign pwr_good = hold_low ? '0 : d3;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a); #1; d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] r;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      rd(0, r);
      if (!r[8]) break;
      @(posedge clk); #1; n++;
    end
  endtask

  // {partition id, expected power status after the toggle}
  localparam logic [36:0] VEC [6] = '{
    {5'd3,  32'h0000_0008},
    {5'd0,  32'h0000_0009},
    {5'd31, 32'h8000_0009},
    {5'd3,  32'h8000_0001},
    {5'd0,  32'h8000_0000},
    {5'd31, 32'h0000_0000}
  };

  initial begin
    logic [31:0] r;
    int n;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 pwr_en", 32'(pwr_en), 32'h0);
    chk("R1 clamp", 32'(clamp), 32'hFFFF_FFFF);
    rd(1, r); chk("R1 status", r, 0);
    rd(0, r); chk("R1 toggle reg", r, 0);
    rd(4, r); chk("R1 error", r, 0);

    // R3/R6/R9 table walk
    for (int v = 0; v < 6; v++) begin
      wr(0, 32'h100 | 32'(VEC[v][36:32]));
      wait_idle(n);
      rd(1, r); chk("R6 status after toggle", r, VEC[v][31:0]);
      chk("R3 enables after toggle", 32'(pwr_en), VEC[v][31:0]);
      rd(3, r); chk("R9 clamp status", r, 32'hFFFF_FFFF);
    end

    // R2 write without start flag starts nothing
    wr(0, 32'd9);
    rd(0, r); chk("R2 no start busy", r & 32'h100, 0);
    @(posedge clk); #1;
    chk("R2 no start enable", 32'(pwr_en[9]), 0);

    // R4 completion waits for power-good
    hold_low = 1'b1;
    wr(0, 32'h106);
    chk("R4 enable next cycle", 32'(pwr_en[6]), 1);
    rd(0, r); chk("R2 busy set", r & 32'h100, 32'h100);
    repeat (20) @(posedge clk); #1;
    rd(0, r); chk("R4 still busy without good", r & 32'h100, 32'h100);
    rd(1, r); chk("R4 status held low", r, 0);
    hold_low = 1'b0;
    wait_idle(n);
    rd(1, r); chk("R4 status after good", r, 32'h40);
    rd(0, r); chk("R2 start self-clears", r, 32'h6);

    // R4 minimum settle time
    wr(0, 32'h107);
    wait_idle(n);
    chk("R4 settle length", 32'(n >= SETTLE), 1);
    rd(1, r); chk("R6 two powered", r, 32'hC0);

    // R8 clamp release on powered partition
    wr(2, 32'h40);
    rd(2, r); chk("R8 command pending", r, 32'h40);
    @(posedge clk); #1;
    rd(2, r); chk("R8 command self-clears", r, 0);
    chk("R8 clamp released", 32'(clamp[6]), 0);
    chk("R8 other clamp kept", 32'(clamp[7]), 1);
    rd(3, r); chk("R9 clamp status bit", r, 32'hFFFF_FFBF);

    // R5 power-down re-clamps first
    wr(0, 32'h106);
    chk("R5 clamp set", 32'(clamp[6]), 1);
    chk("R5 enable still high", 32'(pwr_en[6]), 1);
    @(posedge clk); #1;
    chk("R5 enable dropped", 32'(pwr_en[6]), 0);
    wait_idle(n);
    rd(1, r); chk("R5 status after off", r, 32'h80);

    // R10 release on unpowered partition
    wr(2, 32'h20);
    rd(4, r); chk("R10 error set", r, 1);
    @(posedge clk); #1;
    chk("R10 clamp kept", 32'(clamp[5]), 1);
    rd(2, r); chk("R10 no pending", r, 0);
    wr(4, 32'h1);
    rd(4, r); chk("R10 error cleared", r, 0);

    // R7 toggle write while busy is ignored
    wr(0, 32'h102);
    wr(0, 32'h104);
    rd(0, r); chk("R7 id kept", r, 32'h102);
    wait_idle(n);
    rd(1, r); chk("R7 only first partition", r, 32'h84);
    chk("R7 ignored enable", 32'(pwr_en[4]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule